// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves data between memory and a single fixed peripheral location. Software programs it through a small register window. There is one configuration word. Beside it sit two buffer slots, each holding a start address and a byte count. The control/status word is changed only through write-one-to-set and write-one-to-clear aliases, and it is read back through a third offset. The channel drains armed slots in turn. When the active slot runs out, the slot is marked done and the channel moves straight on to the other slot if that slot is armed. A buffer-in-use bit shows which slot is active.

Data moves in bursts of 4 or 8 beats, and each beat is 1 or 2 bytes. A burst starts when the peripheral raises its request. Once started, a burst runs on regardless of that request until it finishes, the slot empties, or the slot is disarmed. The memory side is a plain request/acknowledge pair. The address, the direction and the beat width are valid while `mem_req` is high, and a beat completes on a cycle where `mem_ack` is high. An interrupt line reports completion and errors.

Top module: `pdma_chan`

## Requirements
- R1: Byte offsets, selected by `reg_addr[4:2]`: config 0x00, status-set 0x04, status-clear 0x08, status-read 0x0C, slot A address 0x10, slot A count 0x14, slot B address 0x18, slot B count 0x1C.
  Status bits: 0 run, 1 interrupt enable, 2 error, 3 done A, 4 start A, 5 done B, 6 start B, 7 buffer-in-use (1 = B active).
  A 1 written at the set offset sets the bit, and a 1 written at the clear offset clears it. Zero bits have no effect. Bit 7 cannot be written. Reads at the set and clear offsets return 0, and after reset the status word reads 0.
- R2: Config bits: bit 0 direction (1 = device to memory, which drives `mem_we` high), bit 1 enable, bit 2 burst (0 = 4 beats, 1 = 8 beats), bit 3 width (0 = 1 byte, 1 = 2 bytes, shown on `mem_wide`).
  `dev_addr` unpacks the peripheral address. Config bits 31:28 become address bits 31:28, config bits 27:8 become address bits 21:2, and all other address bits are 0.
- R3: A beat is requested only when all of the following hold: run is set, config enable is set, error is clear, and the active slot's start bit is set. Each acknowledged beat adds the beat width to the active address and subtracts it from the count, stopping at zero.
- R4: A burst begins on `periph_req` and then continues without it. `mem_req` stays high until acknowledged. Clearing run takes effect only at the end of the current burst. Setting run again continues from the held address and count.
- R5: When the active count reaches zero, the hardware clears that slot's start bit and sets its done bit. A slot armed with count 0 completes without any beat.
- R6: If the other slot is armed when the active slot completes, buffer-in-use toggles and the transfer continues from the other slot's address.
- R7: If the channel is idle, its active slot is unarmed and the other slot is armed, buffer-in-use toggles to the armed slot.
- R8: If a burst is about to start while the active address is not 4-byte aligned, or its count exceeds 0x1FFF, the error bit is set and no beat is requested. The channel stays halted until software clears error.
- R9: `irq` is high exactly while interrupt enable is set and at least one of error, done A or done B is set.
- R10: The slot address and count registers read back the live position and the bytes remaining.
- R11: While config enable is 0, an armed and running channel requests no beats and leaves its slot registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| periph_req | input | 1 | Peripheral transfer request |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | 32 | Memory address of the current beat |
| mem_we | output | 1 | 1 = write memory (device to memory) |
| mem_wide | output | 1 | 1 = 2-byte beat, 0 = 1-byte beat |
| mem_ack | input | 1 | Memory beat acknowledge |
| dev_addr | output | 32 | Unpacked peripheral address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a pause that lands in the middle of a burst, followed by a resume. Both the acknowledge timing and the start of each burst are random. The stimulus holds the peripheral request high, clears run while data is moving and then lets the channel go quiet. It then checks that the number of beats delivered is a whole number of bursts and that the slot registers match that number before setting run again. Ping-pong order also depends on the buffer-in-use bit left over from earlier transfers. The bench therefore tracks that bit across randomly sized pairs of slots, which exercises both A-first and B-first sequences.

// File: rtl/pdma_chan.sv
module pdma_chan #(
  parameter int CNT_W   = 16,
  parameter int MAX_CNT = 'h1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        periph_req,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic        mem_we,
  output logic        mem_wide,
  input  logic        mem_ack,
  output logic [31:0] dev_addr,
  output logic        irq
);

  localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_CNT);

  logic [31:0]      cfg;
  logic [6:0]       st, st_nx;
  logic             biu, busy;
  logic [2:0]       left;
  logic [31:0]      s_addr [2];
  logic [CNT_W-1:0] s_cnt  [2];

  wire [2:0] wsel   = reg_addr[4:2];
  wire       wr_set = reg_wr && (wsel == 3'd1);
  wire       wr_clr = reg_wr && (wsel == 3'd2);

  wire             act_arm  = biu ? st[6] : st[4];
  wire             oth_arm  = biu ? st[4] : st[6];
  wire [31:0]      act_addr = s_addr[biu];
  wire [CNT_W-1:0] act_cnt  = s_cnt[biu];
  wire [1:0]       step     = cfg[3] ? 2'd2 : 2'd1;
  wire [CNT_W-1:0] stepc    = CNT_W'(step);

  wire can_go      = st[0] & cfg[1] & ~st[2] & act_arm & ~busy;
  wire bad         = (act_addr[1:0] != 2'b00) || (act_cnt > CMAX);
  wire start_burst = can_go & ~bad & periph_req & (act_cnt != '0);
  wire zero_fin    = can_go & ~bad & (act_cnt == '0);
  wire set_err     = can_go & bad;
  wire beat        = mem_req & mem_ack;
  wire last        = beat & (act_cnt <= stepc);
  wire fin         = last | zero_fin;
  wire swap        = ~busy & ~act_arm & oth_arm;

  assign mem_req  = busy & act_arm;
  assign mem_addr = act_addr;
  assign mem_we   = cfg[0];
  assign mem_wide = cfg[3];
  assign dev_addr = {cfg[31:28], 6'b0, cfg[27:8], 2'b00};
  assign irq      = st[1] & (st[2] | st[3] | st[5]);

  always_comb begin
    st_nx = st;
    if (wr_set) st_nx = st_nx | reg_wdata[6:0];
    if (wr_clr) st_nx = st_nx & ~reg_wdata[6:0];
    if (fin) begin
      if (biu) begin
        st_nx[6] = 1'b0;
        st_nx[5] = 1'b1;
      end else begin
        st_nx[4] = 1'b0;
        st_nx[3] = 1'b1;
      end
    end
    if (set_err) st_nx[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= '0;
      biu <= 1'b0;
      cfg <= '0;
    end else begin
      st <= st_nx;
      if ((fin && oth_arm) || swap) biu <= ~biu;
      if (reg_wr && wsel == 3'd0) cfg <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (start_burst) begin
      busy <= 1'b1;
      left <= cfg[2] ? 3'd7 : 3'd3;
    end else if (busy) begin
      if (!act_arm || (beat && (last || left == 3'd0))) busy <= 1'b0;
      else if (beat) left <= left - 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        s_addr[i] <= '0;
        s_cnt[i]  <= '0;
      end else begin
        if (reg_wr && wsel == 3'(4 + 2 * i))
          s_addr[i] <= reg_wdata;
        else if (beat && biu == i[0])
          s_addr[i] <= s_addr[i] + {30'b0, step};
        if (reg_wr && wsel == 3'(5 + 2 * i))
          s_cnt[i] <= reg_wdata[CNT_W-1:0];
        else if (beat && biu == i[0])
          s_cnt[i] <= (s_cnt[i] <= stepc) ? '0 : s_cnt[i] - stepc;
      end
    end
  end

  always_comb begin
    case (wsel)
      3'd0:    reg_rdata = cfg;
      3'd3:    reg_rdata = {24'b0, biu, st};
      3'd4:    reg_rdata = s_addr[0];
      3'd5:    reg_rdata = 32'(s_cnt[0]);
      3'd6:    reg_rdata = s_addr[1];
      3'd7:    reg_rdata = 32'(s_cnt[1]);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [31:0]      mem_addr,
  input logic [6:0]       st,
  input logic             biu,
  input logic             busy,
  input logic             wide,
  input logic [CNT_W-1:0] act_cnt
);

  wire [CNT_W-1:0] stp = wide ? CNT_W'(2) : CNT_W'(1);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !reg_wr) |=> mem_req); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && act_cnt > stp && !reg_wr) |=> (mem_addr == $past(mem_addr) + 32'($past(stp)))); // R3

  AST_DONE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && act_cnt <= stp && !biu && !reg_wr) |=> (st[3] && !st[4])); // R5

  AST_DONE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && act_cnt <= stp && biu && !reg_wr) |=> (st[5] && !st[6])); // R5

  AST_BIU_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(biu)); // R6

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st[2] && !busy) |=> !busy); // R8

endmodule

bind pdma_chan pdma_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .st(st), .biu(biu),
  .busy(busy), .wide(cfg[3]), .act_cnt(act_cnt)
);

// File: tb/sim_pdma_chan.sv
module sim_pdma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        mem_req, mem_we, mem_wide, irq;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr, dev_addr;

  pdma_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_ack(mem_ack), .dev_addr(dev_addr), .irq(irq)
  );

  localparam logic [4:0] O_CFG = 5'h00, O_SET = 5'h04, O_CLR = 5'h08, O_ST = 5'h0C;
  localparam logic [4:0] O_AA = 5'h10, O_AC = 5'h14, O_BA = 5'h18, O_BC = 5'h1C;

  int n_chk = 0, n_fail = 0;
  int log_n = 0;
  logic [31:0] log_a [0:4095];
  int preq_mode = 0;
  bit exp_biu = 1'b0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    periph_req = (preq_mode == 1) || (preq_mode == 2 && ($urandom % 3 != 0));
    mem_ack = mem_req && ($urandom % 4 != 0);
    if (mem_req && mem_ack && log_n < 4096) begin
      log_a[log_n] = mem_addr;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(O_ST, s);
      if ((s & 32'h54) != 0 && (s & 32'h04) != 0) break;
      if ((s & 32'h50) == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] mkcfg(input bit dir, input bit en, input bit b8, input bit w2);
    return {28'b0, w2, b8, en, dir};
  endfunction

  task automatic check_seq(input int base, input logic [31:0] a0, input int n0,
                           input logic [31:0] a1, input int n1, input int w, input string tag);
    int b0, b1, bad;
    b0 = (n0 + w - 1) / w;
    b1 = (n1 + w - 1) / w;
    chk(log_n - base == b0 + b1, {tag, " beat count"}, 32'(log_n - base), 32'(b0 + b1));
    bad = -1;
    for (int k = 0; k < b0 + b1 && base + k < log_n; k++) begin
      logic [31:0] e;
      e = (k < b0) ? a0 + 32'(k * w) : a1 + 32'((k - b0) * w);
      if (bad < 0 && log_a[base + k] != e) begin
        bad = k;
        chk(1'b0, {tag, " address order"}, log_a[base + k], e);
      end
    end
    if (bad < 0) chk(1'b1, tag, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base, n;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R9 reset state
    rd_chk(O_ST, 32'h0, "R1 reset status");
    rd_chk(O_CFG, 32'h0, "R1 reset config");
    chk(!irq && !mem_req, "R9 reset irq/req", {30'b0, irq, mem_req}, 0);

    // R1 set/clear semantics
    wr(O_SET, 32'h03);  rd_chk(O_ST, 32'h03, "R1 set");
    wr(O_SET, 32'h80);  rd_chk(O_ST, 32'h03, "R1 buffer-in-use not writable");
    wr(O_CLR, 32'h00);  rd_chk(O_ST, 32'h03, "R1 zero clear no effect");
    wr(O_SET, 32'h00);  rd_chk(O_ST, 32'h03, "R1 zero set no effect");
    wr(O_CLR, 32'h02);  rd_chk(O_ST, 32'h01, "R1 clear one bit");
    rd_chk(O_SET, 32'h0, "R1 set alias reads zero");
    wr(O_CLR, 32'h7F);  rd_chk(O_ST, 32'h00, "R1 clear all");

    // R2 config unpacking
    wr(O_CFG, {4'hA, 20'h12345, 4'h5, 4'b1001});
    #1;
    chk(dev_addr == {4'hA, 6'b0, 20'h12345, 2'b00}, "R2 dev_addr", dev_addr, {4'hA, 6'b0, 20'h12345, 2'b00});
    chk(mem_we && mem_wide, "R2 direction/width", {30'b0, mem_we, mem_wide}, 32'h3);

    // R11 enable off
    preq_mode = 1;
    wr(O_CFG, mkcfg(0, 0, 0, 0));
    wr(O_AA, 32'h0000_0800); wr(O_AC, 8);
    base = log_n;
    wr(O_SET, 32'h11);
    repeat (30) @(negedge clk);
    chk(log_n == base, "R11 no beats while disabled", 32'(log_n - base), 0);
    rd_chk(O_AC, 8, "R11 count unchanged");
    rd_chk(O_ST, 32'h11, "R11 still armed");
    wr(O_CLR, 32'h11);

    // R3 R5 R9 R10 single slot A
    preq_mode = 2;
    wr(O_CFG, mkcfg(0, 1, 0, 0));
    wr(O_AA, 32'h0000_1000); wr(O_AC, 10);
    base = log_n;
    wr(O_SET, 32'h13);
    wait_idle();
    check_seq(base, 32'h1000, 10, 0, 0, 1, "R3 single slot");
    rd_chk(O_ST, 32'h0B, "R5 done A set start A clear");
    rd_chk(O_AA, 32'h100A, "R10 live address");
    rd_chk(O_AC, 0, "R10 remaining zero");
    chk(irq, "R9 irq on done", {31'b0, irq}, 1);
    chk(!mem_we, "R2 memory read direction", {31'b0, mem_we}, 0);
    wr(O_CLR, 32'h08);
    #1 chk(!irq, "R9 irq after ack", {31'b0, irq}, 0);

    // R6 ping-pong, 2-byte beats, 8-beat bursts, device to memory
    wr(O_CFG, mkcfg(1, 1, 1, 1));
    wr(O_AA, 32'h0000_2000); wr(O_AC, 12);
    wr(O_BA, 32'h0000_3000); wr(O_BC, 7);
    base = log_n;
    wr(O_SET, 32'h53);
    wait_idle();
    check_seq(base, 32'h2000, 12, 32'h3000, 7, 2, "R6 ping-pong");
    rd_chk(O_ST, 32'hAB, "R6 both done, B in use");
    chk(mem_we && mem_wide, "R2 write direction", {30'b0, mem_we, mem_wide}, 3);
    wr(O_CLR, 32'h28);
    exp_biu = 1'b1;

    // R7 idle switch to the armed slot
    wr(O_CFG, mkcfg(0, 1, 0, 1));
    wr(O_AA, 32'h0000_4000); wr(O_AC, 6);
    base = log_n;
    wr(O_SET, 32'h10);
    wait_idle();
    check_seq(base, 32'h4000, 6, 0, 0, 2, "R7 idle switch");
    rd_chk(O_ST, 32'h0B, "R7 A in use and done");
    wr(O_CLR, 32'h08);
    exp_biu = 1'b0;

    // R4 R10 pause and resume
    preq_mode = 1;
    wr(O_CFG, mkcfg(0, 1, 0, 0));
    wr(O_AA, 32'h0000_5000); wr(O_AC, 100);
    base = log_n;
    wr(O_SET, 32'h10);
    repeat (15) @(negedge clk);
    wr(O_CLR, 32'h01);
    repeat (30) @(negedge clk);
    n = log_n - base;
    chk(n % 4 == 0 && n > 0 && n < 100, "R4 pause at burst boundary", 32'(n), 32'(n - n % 4));
    rd_chk(O_AA, 32'h5000 + 32'(n), "R10 paused address");
    rd_chk(O_AC, 32'(100 - n), "R10 paused count");
    wr(O_SET, 32'h01);
    wait_idle();
    check_seq(base, 32'h5000, 100, 0, 0, 1, "R4 resume");
    rd_chk(O_ST, 32'h0B, "R4 done after resume");
    wr(O_CLR, 32'h08);

    // R8 misaligned start
    wr(O_AA, 32'h0000_6002); wr(O_AC, 4);
    base = log_n;
    wr(O_SET, 32'h10);
    repeat (10) @(negedge clk);
    rd_chk(O_ST, 32'h17, "R8 misaligned sets error");
    chk(log_n == base, "R8 no beats on error", 32'(log_n - base), 0);
    chk(irq, "R9 irq on error", {31'b0, irq}, 1);
    wr(O_CLR, 32'h14);
    rd_chk(O_ST, 32'h03, "R8 error cleared");

    // R8 oversize count
    wr(O_AA, 32'h0000_7000); wr(O_AC, 32'h2000);
    base = log_n;
    wr(O_SET, 32'h10);
    repeat (10) @(negedge clk);
    rd_chk(O_ST, 32'h17, "R8 oversize sets error");
    rd_chk(O_AC, 32'h2000, "R8 count held");
    chk(log_n == base, "R8 no beats oversize", 32'(log_n - base), 0);
    wr(O_CLR, 32'h14);

    // R5 zero count completes without beats
    wr(O_AA, 32'h0000_7100); wr(O_AC, 0);
    base = log_n;
    wr(O_SET, 32'h10);
    repeat (5) @(negedge clk);
    rd_chk(O_ST, 32'h0B, "R5 zero count done");
    chk(log_n == base, "R5 zero count no beats", 32'(log_n - base), 0);
    wr(O_CLR, 32'h08);

    // R3 R6 random ping-pong pairs
    preq_mode = 2;
    for (int it = 0; it < 30; it++) begin
      bit w2, b8;
      int ca, cb, w;
      logic [31:0] aa, ab;
      w2 = 1'($urandom); b8 = 1'($urandom);
      w = w2 ? 2 : 1;
      ca = 1 + $urandom % 40; cb = 1 + $urandom % 40;
      aa = ($urandom % 32'h0010_0000) & ~32'h3;
      ab = ($urandom % 32'h0010_0000) & ~32'h3;
      wr(O_CFG, mkcfg(1'($urandom), 1, b8, w2));
      wr(O_AA, aa); wr(O_AC, 32'(ca));
      wr(O_BA, ab); wr(O_BC, 32'(cb));
      base = log_n;
      wr(O_SET, 32'h53);
      wait_idle();
      if (!exp_biu) check_seq(base, aa, ca, ab, cb, w, "R6 random A-first");
      else          check_seq(base, ab, cb, aa, ca, w, "R6 random B-first");
      exp_biu = ~exp_biu;
      rd(O_ST, v);
      chk(v == {24'b0, exp_biu, 7'h2B}, "R6 random status", v, {24'b0, exp_biu, 7'h2B});
      wr(O_CLR, 32'h28);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule